// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one clause-22 management transaction on a two-wire MDC/MDIO pair for each command the host writes. The host first programs a clock divider, then writes a single 32-bit command word holding the start pattern, opcode, PHY address, register address, turnaround pattern and, for a write, sixteen data bits. The write launches the transaction at once: the block sends a 32-bit all-ones preamble followed by the command word, MSB first, on a management clock derived from the system clock.

For a read, the block lets go of MDIO from the turnaround onward and shifts the sixteen bits the PHY returns into the low half of the command/data register. At the end of every transaction a completion event flag is raised; the host clears it by writing a one to it. A busy flag shows whether a transaction is running, and a command that arrives while one is running is dropped.

The host side is a plain register port: a write strobe with a 2-bit address and 32-bit data, and a separate combinational read address and data. The system reset is asynchronous, active low, and is released synchronously inside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low and every host register (address 0 command/data, 1 event, 2 divider, 3 status) reads as zero.
- R2: A write to address 0 while idle starts a transaction: status bit 0 (busy) reads one from the next clock cycle on.
- R3: Each transaction places 64 bits on mdio_o, sampled by the PHY on MDC rising edges: 32 ones, then command bits 31 down to 0 (bits 31:30 start, 29:28 opcode, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data); mdio_o only changes when MDC falls.
- R4: For a transaction whose opcode (bits 29:28) is not 2'b10, mdio_oe is high for all 64 bit times.
- R5: For opcode 2'b10 (read), mdio_oe is high for bit times 0 to 45 and low from the first turnaround bit (46) through bit 63; the values on mdio_i at MDC rising edges of bits 48 to 63 land, first bit most significant, in bits 15:0 of address 0, while bits 31:16 keep the command.
- R6: When a transaction ends, bit 0 of address 1 is set in the same cycle busy clears; writing a one to that bit clears it, writing a zero leaves it set.
- R7: The divider field is bits 6:1 of address 2 (other bits read zero and are not stored); MDC spends that many system clocks in each half period, so MDC runs at the system clock divided by twice the field.
- R8: While the divider field is zero, MDC stays low and a pending transaction makes no progress; it proceeds once a non-zero field is written.
- R9: A write to address 0 while busy is ignored: neither the frame on the wire nor the register contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 2 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 2 | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable (high = block drives) |
| mdio_i | input | 1 | MDIO input data from the pad |

## Verification
On every cycle the assertions check that MDC is held low while the divider field is zero, that mdio_o moves only on MDC falling edges and that nothing on the bus moves at a rising edge, that a write transaction keeps driving MDIO, that the completion flag rises exactly when busy drops, and that a command written while busy leaves the register unchanged. Only the bench scenarios can show the full bit order of the frame against the command, the read data assembled from a behavioural PHY, the measured MDC period for several divider values, the stalled transaction that resumes after the divider is programmed, and the write-one-to-clear behaviour seen at the host port.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int HOST_AW = 2;
  localparam int HOST_DW = 32;

  typedef enum logic [HOST_AW-1:0] {
    REG_CMD    = 2'd0,
    REG_EVENT  = 2'd1,
    REG_DIVIDE = 2'd2,
    REG_STATUS = 2'd3
  } host_reg_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             active, wrap;

  always_comb begin
    active   = run && (div != '0);
    wrap     = active && (cnt_q == div - 1'b1);
    rise_stb = wrap && !mdc_q;
    fall_stb = wrap && mdc_q;
    cnt_d    = cnt_q;
    mdc_d    = mdc_q;
    if (!active) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R8: a zero divider freezes the management clock low
  assert_mdc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IDX_W = $clog2(PRE_LEN + CMD_W);
  localparam int SEL_W = $clog2(CMD_W);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(PRE_LEN + CMD_W - 1);
  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(PRE_LEN + CMD_W - DATA_W - 2);
  localparam logic [IDX_W-1:0] DAT_POS  = IDX_W'(PRE_LEN + CMD_W - DATA_W);
  localparam logic [IDX_W-1:0] CMD_POS  = IDX_W'(PRE_LEN);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d, nidx, off;
  logic [CMD_W-1:0]  sh_q, sh_d;
  logic              rd_q, rd_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              o_q, o_d, oe_q, oe_d;
  logic [SEL_W-1:0]  sel;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    rdat_d = rdat_q;
    o_d    = o_q;
    oe_d   = oe_q;
    done   = 1'b0;
    nidx   = idx_q + 1'b1;
    off    = nidx - CMD_POS;
    sel    = SEL_W'(CMD_W - 1) - off[SEL_W-1:0];
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sh_d   = cmd;
      rd_d   = (cmd[CMD_W-3 -: 2] == OPC_READ);
      o_d    = 1'b1;
      oe_d   = 1'b1;
    end else if (busy_q) begin
      if (rise_stb && rd_q && (idx_q >= DAT_POS)) begin
        rdat_d = {rdat_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (idx_q == LAST_POS) begin
          done   = 1'b1;
          busy_d = 1'b0;
          o_d    = 1'b1;
          oe_d   = 1'b0;
        end else begin
          idx_d = nidx;
          o_d   = (nidx < CMD_POS) ? 1'b1 : sh_q[sel];
          oe_d  = !(rd_q && (nidx >= TA_POS));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      rdat_q <= '0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      rdat_q <= rdat_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
    end
  end

  assign busy    = busy_q;
  assign done_rd = done && rd_q;
  assign rdata   = rdat_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  // R3: data moves only at a falling MDC edge while a frame runs
  assert_mdio_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_stb) |=> $stable(o_q));

  // R5: a rising MDC edge never disturbs the bus direction or data
  assert_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> ($stable(oe_q) && $stable(o_q)));

  // R4: write frames keep the line driven for their whole length
  assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_q) |-> oe_q);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [HOST_AW-1:0] waddr,
  input  logic [HOST_DW-1:0] wdata,
  input  logic [HOST_AW-1:0] raddr,
  output logic [HOST_DW-1:0] rdata,
  input  logic               busy,
  input  logic               done,
  input  logic               done_rd,
  input  logic [DATA_W-1:0]  rd_result,
  output logic               cmd_start,
  output logic [HOST_DW-1:0] cmd_word,
  output logic [DIV_W-1:0]   div
);
  logic [HOST_DW-1:0] word_q, word_d;
  logic               evt_q, evt_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               cmd_we, evt_we, div_we;

  always_comb begin
    cmd_we    = we && (waddr == REG_CMD);
    evt_we    = we && (waddr == REG_EVENT);
    div_we    = we && (waddr == REG_DIVIDE);
    cmd_start = cmd_we && !busy;
    word_d    = word_q;
    evt_d     = evt_q;
    div_d     = div_q;
    if (cmd_start)
      word_d = wdata;
    else if (done_rd)
      word_d = {word_q[HOST_DW-1:DATA_W], rd_result};
    if (done)
      evt_d = 1'b1;
    else if (evt_we && wdata[0])
      evt_d = 1'b0;
    if (div_we)
      div_d = wdata[DIV_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      evt_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      word_q <= word_d;
      evt_q  <= evt_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    unique case (host_reg_e'(raddr))
      REG_CMD:    rdata = word_q;
      REG_EVENT:  rdata = {{(HOST_DW-1){1'b0}}, evt_q};
      REG_DIVIDE: rdata = {{(HOST_DW-DIV_W-1){1'b0}}, div_q, 1'b0};
      default:    rdata = {{(HOST_DW-1){1'b0}}, busy};
    endcase
  end

  assign cmd_word = wdata;
  assign div      = div_q;

  // R6: completion flag appears exactly when the engine goes idle
  assert_event_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $fell(busy));

  // R9: a command arriving mid-transaction leaves the register alone
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we && !done) |=> $stable(word_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_waddr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic [HOST_AW-1:0] host_raddr,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic               rst_ns;
  logic               busy, done, done_rd, start;
  logic               rise_stb, fall_stb;
  logic [DATA_W-1:0]  rd_result;
  logic [HOST_DW-1:0] cmd_word;
  logic [DIV_W-1:0]   div;

  mdio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ns)
  );

  mdio_host_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ns),
    .we(host_we), .waddr(host_waddr), .wdata(host_wdata),
    .raddr(host_raddr), .rdata(host_rdata),
    .busy(busy), .done(done), .done_rd(done_rd), .rd_result(rd_result),
    .cmd_start(start), .cmd_word(cmd_word), .div(div)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_ns), .run(busy), .div(div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .CMD_W(HOST_DW), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_ns), .start(start), .cmd(cmd_word),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .done_rd(done_rd), .rdata(rd_result),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  raddr = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_bit = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = !clk;

  assign mdio_i = mdio_oe ? mdio_o : phy_bit;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(we), .host_waddr(waddr),
    .host_wdata(wdata), .host_raddr(raddr), .host_rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural PHY and bus monitor, sampled away from the active edge
  logic [63:0] got_o, got_oe;
  logic [15:0] phy_resp = '0;
  int          rcnt = 0;
  int          since_rise = 0;
  int          last_per = 0;
  logic        mdc_prev = 1'b0;

  always @(negedge clk) begin
    cycles++;
    since_rise++;
    if (mdc && !mdc_prev) begin
      if (rcnt < 64) begin
        got_o[63-rcnt]  = mdio_o;
        got_oe[63-rcnt] = mdio_oe;
      end
      if (rcnt > 0) last_per = since_rise;
      since_rise = 0;
      rcnt++;
    end
    if (!mdc && mdc_prev) begin
      phy_bit = (rcnt >= 48 && rcnt < 64) ? phy_resp[63-rcnt] : 1'b1;
    end
    mdc_prev = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  task automatic mon_clear();
    rcnt = 0; got_o = '0; got_oe = '0; last_per = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      hread(2'd3, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [63:0] exp_oe(input logic [31:0] c);
    return (c[29:28] == 2'b10) ? {46'h3FFF_FFFF_FFFF, 18'h0} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] c, input logic [15:0] r);
    return (c[29:28] == 2'b10) ? {c[31:16], r} : c;
  endfunction

  // full transaction: issue, optionally disturb, wait, check frame and registers
  task automatic run_txn(input logic [31:0] c, input logic [15:0] resp,
                         input int div, input bit disturb);
    logic [31:0] v;
    mon_clear();
    phy_resp = resp;
    hwrite(2'd0, c);
    hread(2'd3, v);
    check(v[0] == 1'b1, "R2 busy after command", {32'h0, v}, 64'h1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      hwrite(2'd0, ~c);
    end
    wait_idle();
    check(rcnt == 64, "R3 bit count", 64'(rcnt), 64'd64);
    check(got_o == {32'hFFFF_FFFF, c} || c[29:28] == 2'b10 && got_o[63:18] == {32'hFFFF_FFFF, c[31:18]},
          disturb ? "R9 frame unchanged" : "R3 frame bits", got_o, {32'hFFFF_FFFF, c});
    check(got_oe == exp_oe(c), c[29:28] == 2'b10 ? "R5 read enable" : "R4 write enable",
          got_oe, exp_oe(c));
    check(last_per == 2 * div, "R7 mdc period", 64'(last_per), 64'(2 * div));
    hread(2'd0, v);
    check(v == exp_word(c, resp), disturb ? "R9 register unchanged" : "R5 data register",
          {32'h0, v}, {32'h0, exp_word(c, resp)});
    hread(2'd1, v);
    check(v == 32'h1, "R6 event set", {32'h0, v}, 64'h1);
    hwrite(2'd1, 32'h0);
    hread(2'd1, v);
    check(v == 32'h1, "R6 zero write keeps event", {32'h0, v}, 64'h1);
    hwrite(2'd1, 32'h1);
    hread(2'd1, v);
    check(v == 32'h0, "R6 one write clears event", {32'h0, v}, 64'h0);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c;
    logic [15:0] r;
    int          dv;
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      hread(2'(a), v);
      check(v == 32'h0, "R1 register reset", {32'h0, v}, 64'h0);
    end
    check(!mdc && !mdio_oe, "R1 pins reset", {62'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 field placement: bit 0 not stored
    hwrite(2'd2, 32'h0000_0005);
    hread(2'd2, v);
    check(v == 32'h4, "R7 divider field", {32'h0, v}, 64'h4);

    // R8 zero divider stalls the frame
    hwrite(2'd2, 32'h0);
    mon_clear();
    phy_resp = 16'h0;
    hwrite(2'd0, 32'h5012_0000 | 32'hBEEF);
    repeat (100) @(negedge clk);
    check(rcnt == 0 && !mdc, "R8 mdc idle", 64'(rcnt), 64'h0);
    hread(2'd3, v);
    check(v[0] == 1'b1, "R8 still busy", {32'h0, v}, 64'h1);
    hwrite(2'd2, 32'h4);
    wait_idle();
    check(got_o == {32'hFFFF_FFFF, 32'h5012_BEEF}, "R8 resumes frame", got_o,
          {32'hFFFF_FFFF, 32'h5012_BEEF});
    hwrite(2'd1, 32'h1);

    // directed read and write at divider 1
    hwrite(2'd2, 32'h2);
    run_txn(32'h6086_0000, 16'hA5C3, 1, 1'b0);
    run_txn(32'h5FFE_0001, 16'h0, 1, 1'b0);
    // R9 command while busy
    hwrite(2'd2, 32'h6);
    run_txn(32'h6842_0000, 16'h8001, 3, 1'b1);

    // constrained random
    for (int k = 0; k < 8; k++) begin
      dv = 1 + int'($urandom_range(3));
      c  = {2'b01, ($urandom_range(1) == 1) ? 2'b10 : 2'b01, 10'($urandom), 2'b10, 16'($urandom)};
      r  = 16'($urandom);
      hwrite(2'd2, 32'(dv << 1));
      run_txn(c, r, dv, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule